// File: doc/BRIEF.md
# Triple Timer Counter

The block holds three independent up-counters behind one small synchronous register bus. Each counter has its own six registers. Each register kind forms a group. Inside a group the three timers sit four bytes apart. A counter advances on ticks from one of two tick-enable inputs, which a register bit selects. An optional divider sits between the tick and the counter and divides by a power of two. The counter either runs freely and wraps, or counts up to a programmed limit, returns to zero and raises a pending flag.

Software programs the divider, the limit and the mode, and then starts the counter with a self-clearing restart bit. It services the interrupt by reading the status register, and that read also clears the flag. Each timer drives its own interrupt line. The line is the pending flag gated by an enable bit.

Top module: `triple_timer`

## Requirements
- R1: After reset every register of every timer reads as zero and all interrupt lines are low.
- R2: Register groups sit at byte offsets 0x00 (clock control, 6 bits), 0x0C (counter control), 0x18 (count, read-only), 0x24 (limit), 0x54 (status, read-only) and 0x60 (interrupt enable, bit 0); timer k uses group offset + 4*k. Read data appears on the cycle after the read request. Writes to read-only or unmapped addresses change nothing, and unmapped addresses read as zero.
- R3: With counter control bit 1 clear, the count rises by one per advance and wraps from the all-ones value to zero without raising a flag.
- R4: Clock control bit 0 enables the divider, and bits 4:1 hold N; while the divider is enabled the count advances once per 2^(N+1) selected ticks, and while it is disabled the count advances once per tick, whatever N is.
- R5: Clock control bit 5 selects the tick source: 0 takes `tickA`, 1 takes `tickB`; the other input has no effect.
- R6: While counter control bit 0 is set, the count and the divider hold their value.
- R7: With counter control bit 1 set, an advance at a count equal to the limit returns the count to zero and sets status bit 0.
- R8: A status read returns the pending flags and clears them; a new limit event in the same cycle as the clearing read leaves the flag set.
- R9: Interrupt line k is high exactly while timer k's status bit 0 and enable bit 0 are both set.
- R10: Writing counter control with bit 4 set clears the count and the divider in the same cycle as the other control bits update, raises no flag, and bit 4 always reads back as 0, so a count left above a new limit cannot cause a late event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access request |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| tickA | input | 1 | Tick enable, source 0 |
| tickB | input | 1 | Tick enable, source 1 |
| irq | output | 3 | One interrupt line per timer |

## Verification
A register write takes effect at the clock edge that samples it, and a restart clears the count at that same edge. A tick that is high at an edge is counted at that edge. A limit event sets the flag at the edge of the advance, and the interrupt line follows the flag combinationally in the same cycle. Read data is valid after the edge that follows the request. The bench changes all inputs on falling edges and holds each tick high for exactly one rising edge, so the number of advances is known exactly. It reads counts and status only after those edges, and it checks interrupt lines on the falling edge after the event. The expected counts come from integer arithmetic on the tick totals: a shift for the divider, and a remainder for the limit.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int NUM_TMR = 3;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int STRIDE  = 4;
  localparam int PS_W    = 16;   // divider reaches 2^(15+1)

  localparam logic [ADDR_W-1:0] OFS_CLK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_VAL = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IVL = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_STS = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_IEN = 8'h60;

  localparam int RESTART_BIT = 4;

  typedef struct packed {
    logic       srcSel;
    logic [3:0] psVal;
    logic       psEn;
    logic       stop;
    logic       intervalMode;
  } chanCfg_t;

  typedef struct packed {
    logic restart;
    logic statusClr;
  } chanStb_t;
endpackage

// File: rtl/tmr3_chan.sv
module tmr3_chan import tmr3_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickA,
  input  logic             tickB,
  input  chanCfg_t         cfg,
  input  chanStb_t         stb,
  input  logic [CNT_W-1:0] intervalVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             flag
);
  logic            tickSel;
  logic [PS_W:0]   psSpan;
  logic [PS_W-1:0] psLimit;
  logic [PS_W-1:0] psCnt;
  logic            psDone;
  logic            running;
  logic            step;
  logic            hitEnd;
  logic            evt;

  assign tickSel = cfg.srcSel ? tickB : tickA;
  assign psSpan  = {{(PS_W-1){1'b0}}, 2'b10} << cfg.psVal;
  assign psLimit = psSpan[PS_W-1:0] - PS_W'(1);
  assign psDone  = !cfg.psEn || (psCnt == psLimit);
  assign running = !cfg.stop && tickSel;
  assign step    = running && psDone;
  assign hitEnd  = cfg.intervalMode && (cntVal == intervalVal);
  assign evt     = step && hitEnd && !stb.restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt  <= '0;
      cntVal <= '0;
      flag   <= 1'b0;
    end else begin
      if (stb.restart) begin
        psCnt  <= '0;
        cntVal <= '0;
      end else if (running) begin
        psCnt <= psDone ? '0 : psCnt + PS_W'(1);
        if (psDone) cntVal <= hitEnd ? '0 : cntVal + CNT_W'(1);
      end
      flag <= (flag && !stb.statusClr) || evt;
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (cntVal == '0));  // R10
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.stop && !stb.restart) |=> $stable(cntVal));  // R6
  AST_FREE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.intervalMode && !flag) |=> !flag);  // R3
  AST_LIMIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (step && hitEnd && !stb.restart) |=> (cntVal == '0) && flag);  // R7
  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusClr && evt) |=> flag);  // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusClr && !tickSel) |=> !flag);  // R8
endmodule

// File: rtl/tmr3_regs.sv
module tmr3_regs import tmr3_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busSel,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]    cntVal,
  input  logic [NUM_TMR-1:0]               flag,
  output chanCfg_t [NUM_TMR-1:0]           cfg,
  output chanStb_t [NUM_TMR-1:0]           stb,
  output logic [NUM_TMR-1:0][CNT_W-1:0]    intervalVal,
  output logic [NUM_TMR-1:0]               irqEn
);
  logic                             wrReq;
  logic                             rdReq;
  logic [NUM_TMR-1:0][DATA_W-1:0]   rdPart;
  logic [NUM_TMR-1:0]               cntRdHit;
  logic [DATA_W-1:0]                rdMux;

  assign wrReq = busSel && busWrite;
  assign rdReq = busSel && !busWrite;

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(STRIDE * k);
    logic             hitClk, hitCnt, hitVal, hitIvl, hitSts, hitIen;
    logic [5:0]       clkCtlQ;
    logic [1:0]       cntCtlQ;
    logic [CNT_W-1:0] ivlQ;
    logic             ienQ;
    logic [DATA_W-1:0] rdOne;

    assign hitClk = (busAddr == OFS_CLK + OFF);
    assign hitCnt = (busAddr == OFS_CNT + OFF);
    assign hitVal = (busAddr == OFS_VAL + OFF);
    assign hitIvl = (busAddr == OFS_IVL + OFF);
    assign hitSts = (busAddr == OFS_STS + OFF);
    assign hitIen = (busAddr == OFS_IEN + OFF);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        clkCtlQ <= '0;
        cntCtlQ <= '0;
        ivlQ    <= '0;
        ienQ    <= 1'b0;
      end else if (wrReq) begin
        if (hitClk) clkCtlQ <= busWdata[5:0];
        if (hitCnt) cntCtlQ <= busWdata[1:0];
        if (hitIvl) ivlQ    <= busWdata[CNT_W-1:0];
        if (hitIen) ienQ    <= busWdata[0];
      end
    end

    assign cfg[k] = '{srcSel: clkCtlQ[5], psVal: clkCtlQ[4:1], psEn: clkCtlQ[0],
                      stop: cntCtlQ[0], intervalMode: cntCtlQ[1]};
    assign stb[k] = '{restart: wrReq && hitCnt && busWdata[RESTART_BIT],
                      statusClr: rdReq && hitSts};
    assign intervalVal[k] = ivlQ;
    assign irqEn[k]       = ienQ;
    assign cntRdHit[k]    = rdReq && hitCnt;

    always_comb begin
      rdOne = '0;
      if (hitClk) rdOne = DATA_W'(clkCtlQ);
      if (hitCnt) rdOne = DATA_W'(cntCtlQ);
      if (hitVal) rdOne = DATA_W'(cntVal[k]);
      if (hitIvl) rdOne = DATA_W'(ivlQ);
      if (hitSts) rdOne = DATA_W'(flag[k]);
      if (hitIen) rdOne = DATA_W'(ienQ);
    end
    assign rdPart[k] = rdOne;
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_TMR; k++) rdMux = rdMux | rdPart[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (rdReq) busRdata <= rdMux;
  end

  AST_RESTART_READS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (|cntRdHit) |=> !busRdata[RESTART_BIT]);  // R10
  AST_ONE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb[2].restart, stb[1].restart, stb[0].restart}));  // R2
endmodule

// File: rtl/triple_timer.sv
module triple_timer import tmr3_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               tickA,
  input  logic               tickB,
  output logic [NUM_TMR-1:0] irq
);
  chanCfg_t [NUM_TMR-1:0]            cfg;
  chanStb_t [NUM_TMR-1:0]            stb;
  logic [NUM_TMR-1:0][CNT_W-1:0]     intervalVal;
  logic [NUM_TMR-1:0][CNT_W-1:0]     cntVal;
  logic [NUM_TMR-1:0]                flag;
  logic [NUM_TMR-1:0]                irqEn;

  tmr3_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .flag(flag), .cfg(cfg), .stb(stb),
    .intervalVal(intervalVal), .irqEn(irqEn)
  );

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_chan
    tmr3_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rstN(rstN), .tickA(tickA), .tickB(tickB),
      .cfg(cfg[k]), .stb(stb[k]), .intervalVal(intervalVal[k]),
      .cntVal(cntVal[k]), .flag(flag[k])
    );
    assign irq[k] = flag[k] && irqEn[k];

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
      (!irqEn[k]) |-> !irq[k]);  // R9
  end
endmodule

// File: tb/sim_triple_timer.sv
`timescale 1ns/1ps
module sim_triple_timer;
  localparam int A_CLK = 'h00, A_CNT = 'h0C, A_VAL = 'h18;
  localparam int A_IVL = 'h24, A_STS = 'h54, A_IEN = 'h60;

  logic clk = 0, rstN = 0, busSel = 0, busWrite = 0, tickA = 0, tickB = 0;
  logic [7:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [2:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  triple_timer #(.CNT_W(16)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickA(tickA), .tickB(tickB), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = 8'(a); busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = 8'(a);
    @(negedge clk); busSel = 0; d = busRdata;
  endtask

  task automatic pulseA(int n);
    repeat (n) begin @(negedge clk); tickA = 1; @(negedge clk); tickA = 0; end
  endtask

  task automatic pulseB(int n);
    repeat (n) begin @(negedge clk); tickB = 1; @(negedge clk); tickB = 0; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int grp[6] = '{A_CLK, A_CNT, A_VAL, A_IVL, A_STS, A_IEN};
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    for (int k = 0; k < 3; k++)
      for (int g = 0; g < 6; g++) begin
        rd(grp[g] + 4*k, v);
        check($sformatf("R1 reg %0h", grp[g] + 4*k), v, 0);
      end
    check("R1 irq", 32'(irq), 0);

    // R2: map, stride, read-only and unmapped
    for (int k = 0; k < 3; k++) wr(A_IVL + 4*k, 100 + k);
    for (int k = 0; k < 3; k++) begin
      rd(A_IVL + 4*k, v); check($sformatf("R2 limit t%0d", k), v, 100 + k);
    end
    wr(A_CLK + 4, 32'hFFFF_FFFF);
    rd(A_CLK + 4, v); check("R2 clk width", v, 32'h3F);
    rd(A_CLK, v);     check("R2 clk neighbour", v, 0);
    wr(A_CLK + 4, 0);
    wr(A_VAL, 32'h1234); rd(A_VAL, v); check("R2 count read-only", v, 0);
    wr(8'h30, 32'h55);   rd(8'h30, v); check("R2 unmapped", v, 0);
    wr(A_IEN + 8, 32'hFF); rd(A_IEN + 8, v); check("R2 enable width", v, 1);
    wr(A_IEN + 8, 0);

    // R3: free running count per timer
    for (int k = 0; k < 3; k++) begin
      wr(A_CNT + 4*k, 'h10);
      pulseA(3 + 2*k);
      rd(A_VAL + 4*k, v); check($sformatf("R3 count t%0d", k), v, 3 + 2*k);
    end

    // R5: source select
    wr(A_CLK + 8, 'h20); wr(A_CNT + 8, 'h10); wr(A_CNT, 'h10);
    pulseA(4);
    rd(A_VAL + 8, v); check("R5 tickA ignored", v, 0);
    pulseB(3);
    rd(A_VAL + 8, v); check("R5 tickB counted", v, 3);
    rd(A_VAL, v);     check("R5 tickB ignored on source 0", v, 4);

    // R4: divider sweep
    for (int n = 0; n < 4; n++) begin
      wr(A_CLK, (n << 1) | 1); wr(A_CNT, 'h10);
      pulseA(37);
      rd(A_VAL, v); check($sformatf("R4 divide N=%0d", n), v, 37 >> (n + 1));
    end
    wr(A_CLK, 3 << 1); wr(A_CNT, 'h10);
    pulseA(37);
    rd(A_VAL, v); check("R4 divider off", v, 37);
    // R10: restart clears the divider too
    wr(A_CLK, (1 << 1) | 1); wr(A_CNT, 'h10);
    pulseA(3); wr(A_CNT, 'h10); pulseA(3);
    rd(A_VAL, v); check("R10 divider cleared", v, 0);
    pulseA(1);
    rd(A_VAL, v); check("R10 divider restart span", v, 1);

    // R6: stop
    wr(A_CLK, 0); wr(A_CNT, 'h10); pulseA(4);
    wr(A_CNT, 'h01); pulseA(5);
    rd(A_VAL, v); check("R6 held", v, 4);
    wr(A_CNT, 'h00); pulseA(2);
    rd(A_VAL, v); check("R6 resumed", v, 6);

    // R7, R8, R9: limit sweep on timer 1
    wr(A_IEN + 4, 1);
    foreach (grp[i]) begin end
    for (int s = 0; s < 4; s++) begin
      int lim, t;
      lim = (s == 3) ? 5 : s;
      t = 2*lim + 3;
      wr(A_IVL + 4, lim); wr(A_CNT + 4, 'h12); rd(A_STS + 4, v);
      pulseA(t);
      rd(A_VAL + 4, v); check($sformatf("R7 count lim=%0d", lim), v, t % (lim + 1));
      check($sformatf("R9 irq high lim=%0d", lim), 32'(irq[1]), 1);
      rd(A_STS + 4, v); check($sformatf("R8 status set lim=%0d", lim), v, 1);
      rd(A_STS + 4, v); check($sformatf("R8 status cleared lim=%0d", lim), v, 0);
      check($sformatf("R9 irq low lim=%0d", lim), 32'(irq[1]), 0);
      wr(A_CNT + 4, 'h12); pulseA(lim);
      rd(A_VAL + 4, v); check($sformatf("R7 short count lim=%0d", lim), v, lim);
      rd(A_STS + 4, v); check($sformatf("R7 no early flag lim=%0d", lim), v, 0);
    end

    // R9: enable gating
    wr(A_IEN + 4, 0); wr(A_IVL + 4, 0); wr(A_CNT + 4, 'h12); rd(A_STS + 4, v);
    pulseA(1);
    check("R9 gated off", 32'(irq[1]), 0);
    wr(A_IEN + 4, 1);
    check("R9 pending shows", 32'(irq[1]), 1);
    rd(A_STS + 4, v); check("R8 pending read", v, 1);

    // R8: clearing read coincides with a new event
    pulseA(1);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = 8'(A_STS + 4); tickA = 1;
    @(negedge clk); busSel = 0; tickA = 0;
    check("R8 race read value", busRdata, 1);
    rd(A_STS + 4, v); check("R8 race flag kept", v, 1);
    rd(A_STS + 4, v); check("R8 race then cleared", v, 0);

    // R3: wrap at all-ones, no flag
    wr(A_CLK, 0); wr(A_CNT, 'h10); rd(A_STS, v);
    @(negedge clk); tickA = 1;
    repeat (65538) @(negedge clk);
    tickA = 0;
    rd(A_VAL, v); check("R3 wrapped", v, 2);
    rd(A_STS, v); check("R3 no flag in free mode", v, 0);

    // R10: restart bit reads low; fresh interval after limit change
    wr(A_CNT, 'h13); rd(A_CNT, v); check("R10 readback", v, 'h03);
    wr(A_CLK + 8, 0); wr(A_IVL + 8, 10); wr(A_CNT + 8, 'h12); rd(A_STS + 8, v);
    pulseA(8);
    rd(A_VAL + 8, v); check("R10 pre count", v, 8);
    wr(A_CNT + 8, 'h03); wr(A_IVL + 8, 3); wr(A_CNT + 8, 'h12);
    rd(A_VAL + 8, v); check("R10 fresh zero", v, 0);
    rd(A_STS + 8, v); check("R10 no stale flag", v, 0);
    pulseA(3);
    rd(A_VAL + 8, v); check("R10 at limit", v, 3);
    rd(A_STS + 8, v); check("R10 not yet", v, 0);
    pulseA(1);
    rd(A_VAL + 8, v); check("R10 wrapped to zero", v, 0);
    rd(A_STS + 8, v); check("R10 flag on limit", v, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule